// File: doc/BRIEF.md
# Dual-Gated Load Register with Tristate Bus Drive

A small parallel-load storage register meant to sit on a shared bus. A word presented on the data input is captured on a rising clock edge. The capture happens only when two active-low load strobes are both asserted. In every other case the register keeps the word it already holds. An active-high asynchronous clear forces the stored word to zero at any moment and overrides loading.

The stored word reaches the bus through tristate drivers. The drivers conduct only while two active-low drive strobes are both low. If either strobe is high, every output bit floats at high impedance. The drive path is fully separate from the storage path. Loads and clears still take effect while the bus is released, and the updated word appears as soon as the drivers are enabled again.

Top module: `gated_bus_reg`

## Requirements
- R1: After the asynchronous clear is released, with both drive strobes low, the bus reads all zeros.
- R2: On a rising clock edge with clear low and both load strobes (`ld_n_a`, `ld_n_b`) low, the stored word becomes `din`.
- R3: On a rising clock edge where either load strobe is high, the stored word is unchanged.
- R4: Raising `rst_async` clears the stored word to zero at once, without waiting for a clock edge.
- R5: While both drive strobes (`drv_n_a`, `drv_n_b`) are low, `bus_q` equals the stored word on every bit.
- R6: While either drive strobe is high, every bit of `bus_q` is high impedance (`z`).
- R7: The drive strobes have no effect on storage. Loads and clears made while the bus is released are visible once it is driven again.
- R8: Changes to `din` and the load strobes between rising edges do not alter the stored word.
- R9: A rising edge that occurs while clear is high leaves the word at zero, even if both load strobes are low.
- R10: After the clear is released, the word stays zero until the first rising edge on which both load strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_async | input | 1 | Asynchronous clear, active high |
| ld_n_a | input | 1 | First load strobe, active low |
| ld_n_b | input | 1 | Second load strobe, active low |
| drv_n_a | input | 1 | First drive strobe, active low |
| drv_n_b | input | 1 | Second drive strobe, active low |
| din | input | WIDTH (4) | Word to capture |
| bus_q | output | WIDTH (4) | Tristate bus output |

## Verification
Two pairs of events can coincide. The first pair is a load edge and an active clear: the bench holds the clear high across a rising edge while both load strobes are low and new data is present, and expects a zero word. The second pair is a load or clear and a released bus: the bench loads and clears while the drive strobes are high. It checks that the bus reads `z` during that time, then re-enables the drivers and compares the bus with its behavioural model of the stored word.

// File: rtl/gbr_pkg.sv
package gbr_pkg;

    // Action taken by the storage stage at a clock edge
    typedef enum logic {
        ACT_HOLD = 1'b0,
        ACT_LOAD = 1'b1
    } store_act_e;

    function automatic store_act_e pick_action(input logic strobe_ok);
        return strobe_ok ? ACT_LOAD : ACT_HOLD;
    endfunction

endpackage

// File: rtl/gbr_strobe_gate.sv
// Combines N active-low strobes: output is high only when all are low
module gbr_strobe_gate #(
    parameter int N = 2
) (
    input  logic [N-1:0] strobe_n,
    output logic         all_low
);
    always_comb begin
        all_low = ~|strobe_n;
    end
endmodule

// File: rtl/gbr_store.sv
// Storage stage, two-process: next state in a struct, registered with async clear
module gbr_store
    import gbr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_async,
    input  logic         load_ok,
    input  logic [W-1:0] din,
    output logic [W-1:0] word_q
);
    typedef struct packed {
        logic [W-1:0] word;
    } store_t;

    store_t st_d, st_q;
    store_act_e act_d;

    always_comb begin
        st_d  = st_q;
        act_d = pick_action(load_ok);
        case (act_d)
            ACT_LOAD: st_d.word = din;
            default:  st_d.word = st_q.word;
        endcase
    end

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q = st_q.word;
endmodule

// File: rtl/gbr_bus_drv.sv
// Per-bit tristate drivers onto the shared bus
module gbr_bus_drv #(
    parameter int W = 4
) (
    input  logic         drive_ok,
    input  logic [W-1:0] word,
    output logic [W-1:0] bus
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bus[i] = drive_ok ? word[i] : 1'bz;
    end
endmodule

// File: rtl/gated_bus_reg.sv
module gated_bus_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_async,
    input  logic             ld_n_a,
    input  logic             ld_n_b,
    input  logic             drv_n_a,
    input  logic             drv_n_b,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] bus_q
);
    localparam int NSTROBE = 2;

    logic             load_ok;
    logic             drive_ok;
    logic [WIDTH-1:0] stored_q;

    gbr_strobe_gate #(.N(NSTROBE)) u_load_gate (
        .strobe_n ({ld_n_b, ld_n_a}),
        .all_low  (load_ok)
    );

    gbr_strobe_gate #(.N(NSTROBE)) u_drive_gate (
        .strobe_n ({drv_n_b, drv_n_a}),
        .all_low  (drive_ok)
    );

    gbr_store #(.W(WIDTH)) u_store (
        .clk       (clk),
        .rst_async (rst_async),
        .load_ok   (load_ok),
        .din       (din),
        .word_q    (stored_q)
    );

    gbr_bus_drv #(.W(WIDTH)) u_drv (
        .drive_ok (drive_ok),
        .word     (stored_q),
        .bus      (bus_q)
    );
endmodule

// File: rtl/gbr_checker.sv
module gbr_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         ld_n_a,
    input logic         ld_n_b,
    input logic         drv_n_a,
    input logic         drv_n_b,
    input logic [W-1:0] din,
    input logic [W-1:0] stored,
    input logic [W-1:0] bus_q
);
    // R2: both load strobes low at an edge captures din
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ld_n_a && !ld_n_b) |=> (stored == $past(din)));

    // R3, R8: a raised load strobe holds the word
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!rst && (ld_n_a || ld_n_b)) |=> $stable(stored));

    // R4, R9: clear seen at an edge leaves zero at the next
    p_clear_r4: assert property (@(posedge clk)
        rst |=> (stored == '0));

    // R5: enabled drivers present the stored word
    p_drive_r5: assert property (@(posedge clk) disable iff (rst)
        (!drv_n_a && !drv_n_b) |-> (bus_q == stored));
endmodule

bind gated_bus_reg gbr_checker #(.W(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst_async),
    .ld_n_a  (ld_n_a),
    .ld_n_b  (ld_n_b),
    .drv_n_a (drv_n_a),
    .drv_n_b (drv_n_b),
    .din     (din),
    .stored  (stored_q),
    .bus_q   (bus_q)
);

// File: tb/tb_gated_bus_reg.sv
`timescale 1ns/1ps
module tb_gated_bus_reg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_async = 1'b1;
    logic         ld_n_a = 1'b1, ld_n_b = 1'b1;
    logic         drv_n_a = 1'b0, drv_n_b = 1'b0;
    logic [W-1:0] din = '0;
    wire  [W-1:0] bus_q;

    int checks = 0;
    int failures = 0;
    int model = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    gated_bus_reg #(.WIDTH(W)) dut (
        .clk(clk), .rst_async(rst_async),
        .ld_n_a(ld_n_a), .ld_n_b(ld_n_b),
        .drv_n_a(drv_n_a), .drv_n_b(drv_n_b),
        .din(din), .bus_q(bus_q)
    );

    // Behavioural reference of the stored word
    always @(posedge clk or posedge rst_async) begin
        if (rst_async) model = 0;
        else if (ld_n_a == 1'b0 && ld_n_b == 1'b0) model = int'(din);
    end

    task automatic check_bus(input string req);
        logic [W-1:0] exp;
        checks++;
        if (drv_n_a || drv_n_b) exp = 4'bzzzz;
        else exp = model[W-1:0];
        if (bus_q !== exp) begin
            failures++;
            $display("FAIL %s: bus_q=%b expected=%b at %0t", req, bus_q, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) check_bus(cur_req);
    end

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic set_ld(input logic a, input logic b, input logic [W-1:0] d);
        ld_n_a = a; ld_n_b = b; din = d;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: clear held across edges, then released
        repeat (2) tick();
        rst_async = 1'b0;
        tick();
        cur_req = "R1"; check_bus("R1");

        // R10: released, strobes high, stays zero
        cur_req = "R10";
        set_ld(1'b1, 1'b0, 4'hF);
        tick(); check_bus("R10");
        set_ld(1'b0, 1'b1, 4'hE);
        tick(); check_bus("R10");

        // R2: loads of several patterns
        cur_req = "R2";
        foreach (din[i]) begin end
        for (int k = 0; k < 6; k++) begin
            set_ld(1'b0, 1'b0, 4'(k * 5 + 3));
            tick(); check_bus("R2");
        end
        set_ld(1'b0, 1'b0, 4'hA);
        tick(); check_bus("R2");

        // R3: each strobe alone, and both, block capture
        cur_req = "R3";
        set_ld(1'b1, 1'b0, 4'h5); tick(); check_bus("R3");
        set_ld(1'b0, 1'b1, 4'h6); tick(); check_bus("R3");
        set_ld(1'b1, 1'b1, 4'h7); tick(); check_bus("R3");

        // R8: load strobes low between edges only
        cur_req = "R8";
        set_ld(1'b0, 1'b0, 4'h3);
        #3;
        set_ld(1'b1, 1'b1, 4'hC);
        tick(); check_bus("R8");
        if (bus_q !== 4'hA) begin
            failures++;
            $display("FAIL R8: bus_q=%b expected=%b", bus_q, 4'hA);
        end
        checks++;

        // R6: each drive strobe releases the bus
        cur_req = "R6";
        drv_n_a = 1'b1; #1; check_bus("R6");
        drv_n_a = 1'b0; drv_n_b = 1'b1; #1; check_bus("R6");
        drv_n_a = 1'b1; #1; check_bus("R6");
        if (bus_q !== 4'bzzzz) begin
            failures++;
            $display("FAIL R6: bus_q=%b expected=zzzz", bus_q);
        end
        checks++;

        // R7: load while released, then drive again
        cur_req = "R7";
        set_ld(1'b0, 1'b0, 4'h9);
        tick(); check_bus("R7");
        set_ld(1'b1, 1'b1, 4'h0);
        tick();
        drv_n_a = 1'b0; drv_n_b = 1'b0; #1;
        check_bus("R7");
        if (bus_q !== 4'h9) begin
            failures++;
            $display("FAIL R7: bus_q=%b expected=%b", bus_q, 4'h9);
        end
        checks++;

        // R5: driven bus follows new loads
        cur_req = "R5";
        set_ld(1'b0, 1'b0, 4'h6);
        tick(); check_bus("R5");

        // R4: asynchronous clear away from any edge
        cur_req = "R4";
        set_ld(1'b1, 1'b1, 4'h0);
        rst_async = 1'b1; #1;
        check_bus("R4");
        if (bus_q !== 4'h0) begin
            failures++;
            $display("FAIL R4: bus_q=%b expected=0000", bus_q);
        end
        checks++;

        // R9: edge with clear high and load strobes low stays zero
        cur_req = "R9";
        set_ld(1'b0, 1'b0, 4'hB);
        tick(); check_bus("R9");
        tick(); check_bus("R9");
        #5;
        set_ld(1'b1, 1'b1, 4'hB);
        #2;
        rst_async = 1'b0;
        tick(); check_bus("R10");

        // R7: clear while released is seen after re-enable
        cur_req = "R7";
        set_ld(1'b0, 1'b0, 4'hD);
        tick();
        set_ld(1'b1, 1'b1, 4'h0);
        drv_n_b = 1'b1; #1; check_bus("R7");
        #5;
        rst_async = 1'b1;
        tick(); check_bus("R7");
        #5;
        rst_async = 1'b0;
        tick();
        drv_n_b = 1'b0; #1;
        check_bus("R7");
        if (bus_q !== 4'h0) begin
            failures++;
            $display("FAIL R7: bus_q=%b expected=0000", bus_q);
        end
        checks++;

        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule